// File: doc/BRIEF.md
# Masked-Write GPIO Pad Controller

This block gives software direct control of eight pairs of open-drain pads, so that it can drive a two-wire serial bus (I2C or a display data channel) bit by bit. Each pair has a clock line and a data line. Each line has a direction field, an output-value field and a sampled-input field. All three sit in one 32-bit control word, and there are eight such words on a simple memory-mapped register bus.

Each writable field has its own mask bit in the same data word. A write changes only the fields whose mask bit is set. Software can therefore flip one line's direction or level without reading the word first, and without disturbing the other line. The pads are open-drain: a line is driven low only when it is set as an output with value 0. In every other case it is released, and the external pull-up, or another device on the bus, sets the level. Each pad input passes through a two-flop synchronizer before it shows up in the input field.

Top module: `gpio_pad_bank`

## Requirements
- R1: While reset is held and just after it, no line is pulled low, every line is an input with output value 1, and the read data port holds 0. Asserting reset releases every pad at once, without waiting for a clock.
- R2: Control word n (n = 0..7) responds at byte address 0x5010 + 4*n. A write to any other address (below 0x5010, at 0x5030 or above, or not a multiple of 4) changes nothing, and a read of such an address returns 0.
- R3: Clock-line fields are bit 0 = direction mask, bit 1 = direction (1 = output), bit 2 = value mask, bit 3 = output value, bit 4 = sampled input. The data-line fields use the same layout at bits 8 to 12.
- R4: A write updates a line's direction only when its direction mask bit is 1, and its output value only when its value mask bit is 1. A field whose mask bit is 0 keeps its previous value.
- R5: Mask bits and all bits outside the two field groups read back as 0.
- R6: A line's pull-low output is 1 exactly when its direction is output and its value is 0. The pull-low outputs change only in the cycle after a write.
- R7: The input field shows the pad level through two clock stages. A read issued in the cycle the pad changes, or in the next cycle, returns the old level. A read issued two cycles after the change returns the new level.
- R8: Read data is registered. It carries the addressed word in the cycle after a read strobe and holds its value while no read is issued.
- R9: A read and a write to the same word in the same cycle return the word as it was before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data, including mask bits |
| bus_rdata | output | 32 | Registered read data |
| pad_scl_in | input | 8 | Pad level of each clock line |
| pad_sda_in | input | 8 | Pad level of each data line |
| pad_scl_pull | output | 8 | Drive clock line low (open-drain enable) |
| pad_sda_pull | output | 8 | Drive data line low (open-drain enable) |

## Verification
The bench writes words with only one mask set, and with data bits set but no masks. A design that ignored the masks would change the wrong field or both fields. It also writes to misaligned and out-of-range addresses, which an address decoder that drops the low bits or the upper bound would alias onto a real word. It reads a line one, two and three cycles after an external device pulls that line low. A synchronizer with too few or too many stages returns the new level a cycle early or a cycle late. It also issues a read and a write to the same word in one cycle, where a design that bypassed the write data would return the new word instead of the old one.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

  // Field positions inside one line's five-bit group
  localparam int FLD_DIR_MSK = 0;
  localparam int FLD_DIR     = 1;
  localparam int FLD_VAL_MSK = 2;
  localparam int FLD_VAL     = 3;
  localparam int FLD_IN      = 4;
  // Offset of the data-line group above the clock-line group
  localparam int LINE_STRIDE = 8;
  localparam int LINES_PER_REG = 2;

  typedef struct packed {
    logic dir;  // 1 = output
    logic val;  // level driven when output
  } line_cfg_t;

  localparam line_cfg_t LINE_RESET = '{dir: 1'b0, val: 1'b1};

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= 2'b00;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[1];

endmodule

// File: rtl/in_sync.sv
module in_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] hold_q, hold_d;

  always_comb begin
    meta_d = d_i;
    hold_d = meta_q;
  end

  // Idle bus level is high, so the stages reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      hold_q <= '1;
    end else begin
      meta_q <= meta_d;
      hold_q <= hold_d;
    end
  end

  assign q_o = hold_q;

  // Cycles since reset, so the two-cycle lag check never looks into reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R7: the synchronized level is the pad level of two cycles earlier
  a_r7_two_cycle_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));

endmodule

// File: rtl/line_ctl.sv
module line_ctl
  import gpio_pad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dir_we,
  input  logic dir_d,
  input  logic val_we,
  input  logic val_d,
  output logic dir_q,
  output logic val_q,
  output logic pull_low
);

  line_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (dir_we) cfg_d.dir = dir_d;
    if (val_we) cfg_d.val = val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= LINE_RESET;
    else        cfg_q <= cfg_d;
  end

  assign dir_q    = cfg_q.dir;
  assign val_q    = cfg_q.val;
  assign pull_low = cfg_q.dir & ~cfg_q.val;

  // R4: a field without its mask bit keeps its value
  a_r4_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q));
  a_r4_val_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !val_we |=> $stable(val_q));

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_pad_pkg::*;
#(
  parameter int                NUM_REGS  = 8,
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h5010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_REGS-1:0] pad_scl_in,
  input  logic [NUM_REGS-1:0] pad_sda_in,
  output logic [NUM_REGS-1:0] pad_scl_pull,
  output logic [NUM_REGS-1:0] pad_sda_pull
);

  localparam int                NUM_LINES = NUM_REGS * LINES_PER_REG;
  localparam int                IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(NUM_REGS * 4);

  logic rst_n_s;

  rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // Address decode
  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    offset = bus_addr - BASE_ADDR;
    hit    = (bus_addr >= BASE_ADDR) && (offset < SPAN) && (offset[1:0] == 2'b00);
    idx    = offset[IDX_W+1:2];
  end

  // Pad input synchronization
  logic [NUM_LINES-1:0] pad_vec;
  logic [NUM_LINES-1:0] pad_sync;

  in_sync #(.WIDTH(NUM_LINES)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (pad_vec),
    .q_o   (pad_sync)
  );

  logic [NUM_REGS-1:0]  wr_sel;
  logic [NUM_LINES-1:0] dir_vec, val_vec, pull_vec;
  logic [DATA_W-1:0]    line_word [NUM_LINES];
  logic [DATA_W-1:0]    reg_word  [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign wr_sel[r] = bus_wr && hit && (idx == IDX_W'(r));

    for (genvar k = 0; k < LINES_PER_REG; k++) begin : g_line
      localparam int L = LINES_PER_REG * r + k;
      localparam int B = k * LINE_STRIDE;

      line_ctl u_line (
        .clk      (clk),
        .rst_n    (rst_n_s),
        .dir_we   (wr_sel[r] & bus_wdata[B + FLD_DIR_MSK]),
        .dir_d    (bus_wdata[B + FLD_DIR]),
        .val_we   (wr_sel[r] & bus_wdata[B + FLD_VAL_MSK]),
        .val_d    (bus_wdata[B + FLD_VAL]),
        .dir_q    (dir_vec[L]),
        .val_q    (val_vec[L]),
        .pull_low (pull_vec[L])
      );

      assign line_word[L] = DATA_W'({pad_sync[L], val_vec[L], 1'b0, dir_vec[L], 1'b0}) << B;
    end

    assign reg_word[r]      = line_word[LINES_PER_REG*r] | line_word[LINES_PER_REG*r + 1];
    assign pad_vec[2*r]     = pad_scl_in[r];
    assign pad_vec[2*r + 1] = pad_sda_in[r];
    assign pad_scl_pull[r]  = pull_vec[2*r];
    assign pad_sda_pull[r]  = pull_vec[2*r + 1];
  end

  // Registered read port
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = hit ? reg_word[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // R2: a write that misses the map leaves every line untouched
  a_r2_miss_no_change: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && !hit) |=> ($stable(dir_vec) && $stable(val_vec)));

  // R6: pad drive moves only after a write
  a_r6_pull_after_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(pull_vec) |-> $past(bus_wr));

  // R8: read data holds without a read strobe
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

// File: tb/gpio_pad_bank_bench.sv
module gpio_pad_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_scl_in, pad_sda_in;
  logic [7:0]  pad_scl_pull, pad_sda_pull;
  logic [7:0]  ext_scl, ext_sda;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  // Wired-AND bus: external devices and the block's pull-downs
  assign pad_scl_in = ext_scl & ~pad_scl_pull;
  assign pad_sda_in = ext_sda & ~pad_sda_pull;

  gpio_pad_bank u_gpio_pad_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_scl_in   (pad_scl_in),
    .pad_sda_in   (pad_sda_in),
    .pad_scl_pull (pad_scl_pull),
    .pad_sda_pull (pad_sda_pull)
  );

  // Scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data: act=%h exp=<none>", bus_rdata);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  // Tasks start and end right after a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", t, act, e);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    ext_scl = 8'hFF; ext_sda = 8'hFF;
    idle(3);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 scl pulls", {24'h0, pad_scl_pull}, 32'h0);
    chk("R1 sda pulls", {24'h0, pad_sda_pull}, 32'h0);
    rd(16'h5010, 32'h0000_1818, "R1 word0 reset");
    rd(16'h502C, 32'h0000_1818, "R1 word7 reset");

    // R6 / R3: clock line of word2 driven low
    wr(16'h5018, 32'h0000_0007);
    chk("R6 scl pull word2", {24'h0, pad_scl_pull}, 32'h04);
    idle(3);
    rd(16'h5018, 32'h0000_1802, "R3 scl fields");

    // R4: value mask only
    wr(16'h5018, 32'h0000_000C);
    chk("R4 value-only write", {24'h0, pad_scl_pull}, 32'h0);
    idle(3);
    rd(16'h5018, 32'h0000_181A, "R4 dir kept");

    // R4: data bits without masks
    wr(16'h5018, 32'h0000_0A0A);
    idle(3);
    rd(16'h5018, 32'h0000_181A, "R4 no-mask write");

    // R4: release direction, value kept
    wr(16'h5018, 32'h0000_0001);
    idle(3);
    rd(16'h5018, 32'h0000_1818, "R4 release");

    // R3: data line of word5
    wr(16'h5024, 32'h0000_0700);
    chk("R3 sda pull word5", {24'h0, pad_sda_pull}, 32'h20);
    idle(3);
    rd(16'h5024, 32'h0000_0218, "R3 sda fields");

    // R2: last word and misses
    wr(16'h502C, 32'h0000_0007);
    chk("R2 word7 pull", {24'h0, pad_scl_pull}, 32'h80);
    wr(16'h5011, 32'h0000_0007);
    wr(16'h5030, 32'h0000_0700);
    wr(16'h500C, 32'h0000_0007);
    chk("R2 miss scl", {24'h0, pad_scl_pull}, 32'h80);
    chk("R2 miss sda", {24'h0, pad_sda_pull}, 32'h20);
    rd(16'h5030, 32'h0, "R2 read above");
    rd(16'h500C, 32'h0, "R2 read below");
    rd(16'h5012, 32'h0, "R2 read misaligned");
    idle(2);
    rd(16'h502C, 32'h0000_1802, "R5 word7 masks read 0");

    // R5: all bits written
    wr(16'h5010, 32'hFFFF_FFFF);
    idle(3);
    rd(16'h5010, 32'h0000_1A1A, "R5 unused bits 0");

    // R7: external device pulls data line of word0 low
    ext_sda[0] = 1'b0;
    rd(16'h5010, 32'h0000_1A1A, "R7 same cycle old");
    rd(16'h5010, 32'h0000_1A1A, "R7 one cycle old");
    rd(16'h5010, 32'h0000_0A1A, "R7 two cycles new");
    ext_sda[0] = 1'b1;

    // R8: hold without strobe
    idle(5);
    chk("R8 rdata hold", bus_rdata, 32'h0000_0A1A);

    // R9: read and write together
    bus_wr = 1'b1; bus_wdata = 32'h0000_0007;
    rd(16'h501C, 32'h0000_1818, "R9 old word");
    bus_wr = 1'b0;
    chk("R9 write took", {24'h0, pad_scl_pull}, 32'h88);
    idle(3);
    rd(16'h501C, 32'h0000_1802, "R9 new word");

    // R1: reset in mid-run releases pads at once
    idle(2);
    rst_n = 1'b0;
    #1;
    chk("R1 async scl release", {24'h0, pad_scl_pull}, 32'h0);
    chk("R1 async sda release", {24'h0, pad_sda_pull}, 32'h0);
    idle(2);
    rst_n = 1'b1;
    idle(5);
    rd(16'h502C, 32'h0000_1818, "R1 word7 after reset");
    rd(16'h5024, 32'h0000_1818, "R1 word5 after reset");
    idle(2);

    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: act=%0d pending exp=0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule